// File: doc/BRIEF.md
# Serial Synthesizer Register Loader

The loader takes a 21-bit control word from a host and clocks it into a frequency-synthesizer programming port. It drives three lines: a serial clock, a data line and a latch-enable line. The host can hand over the whole word in one parallel write. It can also send three 7-bit pieces, one after another, and the block joins them into one frame.

Latch enable comes from dedicated sequencing logic. It never comes from a host frame-sync signal. A `mode` input picks one of two latch styles:
- **Pulse style:** latch enable idles low and gives one high pulse after the final bit has been clocked.
- **Gate style:** latch enable idles high, drops before the first clock edge, and stays low for a guaranteed number of cycles after the final bit.

The serial clock rate and the gate hold time are set by parameters.

The host watches `busy` to know when a new word can be sent. An `abort` strobe throws away a half-assembled frame. Input offered while a transfer is running is dropped and reported on `overrun`.

Top module: `synth_loader`

## Requirements
- R1: A parallel word accepted on `word_valid` while idle is sent as exactly 21 serial bits, most significant bit first. Each bit is taken on a rising edge of `sclk`.
- R2: Three chunks accepted on `chunk_valid` form one frame. The first chunk supplies bits 20..14, the second bits 13..7 and the third bits 6..0. No serial clock runs before the third chunk arrives.
- R3: `sdata` changes only when `sclk` falls or while `sclk` is low. It holds steady for the whole high phase.
- R4: `sclk` is low whenever no transfer is running. During a transfer, its rising edges are exactly 2*HALF_DIV system cycles apart.
- R5: In pulse style (`mode`=0), `le` is low at every rising `sclk` edge. After the 21st rising edge, `le` goes high no sooner than HALF_DIV cycles later and stays high for exactly 2*HALF_DIV cycles.
- R6: In gate style (`mode`=1), `le` falls at least HALF_DIV cycles before the first rising `sclk` edge. It rises again no sooner than HOLD_CYC cycles after the 21st rising edge.
- R7: `busy` is high from the cycle after the first chunk (or the parallel word) is accepted. It falls in the same cycle that latch enable completes.
- R8: A word or chunk offered while a transfer is running is ignored: no extra frame is sent. `overrun` is high for one cycle, in the cycle after such an input.
- R9: `abort` clears a partly received frame. `busy` falls, none of its chunks are ever sent, and the next chunk starts a fresh frame.
- R10: `mode` is captured when a frame starts, so changing it mid-transfer has no effect on that transfer. While idle, `le` follows `mode` one cycle later: high in gate style, low in pulse style.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| abort | input | 1 | Discard any partly assembled frame |
| mode | input | 1 | Latch style: 0 trailing pulse, 1 low gate |
| word_valid | input | 1 | Parallel word strobe |
| word_data | input | FRAME_W | Parallel frame value |
| chunk_valid | input | 1 | Chunk strobe |
| chunk_data | input | CHUNK_W | Next chunk, high part first |
| sclk | output | 1 | Serial clock to the synthesizer |
| sdata | output | 1 | Serial data, MSB first |
| le | output | 1 | Latch enable |
| busy | output | 1 | Frame assembling or transfer running |
| overrun | output | 1 | One-cycle flag for dropped input |

## Verification
The bench sends frames as parallel words and as chunk triples, in both latch styles. A reversed bit or chunk order shows up in asymmetric values, and a stuck data line shows up in the all-ones and all-zeros words. A chunk pair followed by an abort, and then a fresh triple, checks whether stale chunks leak into the next frame. Input offered during a running transfer shows whether it is dropped or queued. A style change made just after a start shows whether the style is captured at the start or read live. Timing of latch enable is measured against the serial clock edges to tell the pulse-style window apart from the gate-style hold.

// File: rtl/synth_loader_pkg.sv
package synth_loader_pkg;
  typedef enum logic [2:0] {
    S_IDLE,
    S_SETUP,
    S_HIGH,
    S_LOW,
    S_TAIL,
    S_PULSE
  } seq_state_t;
endpackage

// File: rtl/sl_chunk_asm.sv
module sl_chunk_asm #(
  parameter int FRAME_W = 21,
  parameter int CHUNK_W = 7
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               abort,
  input  logic               seq_busy,
  input  logic               word_valid,
  input  logic [FRAME_W-1:0] word_data,
  input  logic               chunk_valid,
  input  logic [CHUNK_W-1:0] chunk_data,
  output logic               start,
  output logic [FRAME_W-1:0] frame,
  output logic               assembling,
  output logic               overrun
);
  localparam int NCHUNK = FRAME_W / CHUNK_W;
  localparam int CW     = $clog2(NCHUNK);
  localparam int BUF_W  = FRAME_W - CHUNK_W;
  localparam logic [CW-1:0] LAST_IDX = CW'(NCHUNK - 1);

  logic [CW-1:0]    cnt;
  logic [BUF_W-1:0] held;
  logic             busy_all, word_acc, chunk_acc, last_chunk;

  assign busy_all   = (cnt != '0) | seq_busy;
  assign word_acc   = word_valid & ~busy_all & ~abort;
  assign chunk_acc  = chunk_valid & ~seq_busy & ~word_acc & ~abort;
  assign last_chunk = chunk_acc & (cnt == LAST_IDX);
  assign start      = word_acc | last_chunk;
  assign frame      = word_acc ? word_data : {held, chunk_data};
  assign assembling = (cnt != '0);

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt     <= '0;
      held    <= '0;
      overrun <= 1'b0;
    end else begin
      overrun <= (word_valid & busy_all) | (chunk_valid & (seq_busy | word_acc));
      if (abort || last_chunk) begin
        cnt <= '0;
      end else if (chunk_acc) begin
        cnt  <= cnt + 1'b1;
        held <= {held[BUF_W-CHUNK_W-1:0], chunk_data};
      end
    end
  end
endmodule

// File: rtl/sl_shift_seq.sv
module sl_shift_seq
  import synth_loader_pkg::*;
#(
  parameter int FRAME_W  = 21,
  parameter int HALF_DIV = 2,
  parameter int HOLD_CYC = 5
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               start,
  input  logic [FRAME_W-1:0] frame,
  input  logic               mode,
  output logic               sclk,
  output logic               sdata,
  output logic               le,
  output logic               busy
);
  localparam int TMAX = (HOLD_CYC > 2*HALF_DIV) ? HOLD_CYC : 2*HALF_DIV;
  localparam int TW   = $clog2(TMAX + 1);
  localparam int BW   = $clog2(FRAME_W);
  localparam logic [TW-1:0] T_HALF  = TW'(HALF_DIV - 1);
  localparam logic [TW-1:0] T_PULSE = TW'(2*HALF_DIV - 1);
  localparam logic [TW-1:0] T_HOLD  = TW'(HOLD_CYC - 1);

  seq_state_t       st;
  logic [FRAME_W-1:0] sh;
  logic [BW-1:0]    left;
  logic [TW-1:0]    tmr;
  logic             mode_q;

  assign busy = (st != S_IDLE);

  always_ff @(posedge clk) begin
    if (rst) begin
      st     <= S_IDLE;
      sclk   <= 1'b0;
      sdata  <= 1'b0;
      le     <= mode;
      sh     <= '0;
      left   <= '0;
      tmr    <= '0;
      mode_q <= 1'b0;
    end else begin
      case (st)
        S_IDLE: begin
          le <= mode;
          if (start) begin
            sh     <= frame;
            sdata  <= frame[FRAME_W-1];
            le     <= 1'b0;
            mode_q <= mode;
            tmr    <= T_HALF;
            left   <= BW'(FRAME_W - 1);
            st     <= S_SETUP;
          end
        end
        S_SETUP, S_LOW: begin
          if (tmr == '0) begin
            sclk <= 1'b1;
            tmr  <= T_HALF;
            st   <= S_HIGH;
          end else tmr <= tmr - 1'b1;
        end
        S_HIGH: begin
          if (tmr == '0) begin
            sclk <= 1'b0;
            if (left == '0) begin
              tmr <= mode_q ? T_HOLD : T_HALF;
              st  <= S_TAIL;
            end else begin
              sh    <= sh << 1;
              sdata <= sh[FRAME_W-2];
              left  <= left - 1'b1;
              tmr   <= T_HALF;
              st    <= S_LOW;
            end
          end else tmr <= tmr - 1'b1;
        end
        S_TAIL: begin
          if (tmr == '0) begin
            le <= 1'b1;
            if (mode_q) st <= S_IDLE;
            else begin
              tmr <= T_PULSE;
              st  <= S_PULSE;
            end
          end else tmr <= tmr - 1'b1;
        end
        S_PULSE: begin
          if (tmr == '0) begin
            le <= 1'b0;
            st <= S_IDLE;
          end else tmr <= tmr - 1'b1;
        end
        default: st <= S_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/synth_loader.sv
module synth_loader #(
  parameter int FRAME_W  = 21,
  parameter int CHUNK_W  = 7,
  parameter int HALF_DIV = 2,
  parameter int HOLD_CYC = 5
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               abort,
  input  logic               mode,
  input  logic               word_valid,
  input  logic [FRAME_W-1:0] word_data,
  input  logic               chunk_valid,
  input  logic [CHUNK_W-1:0] chunk_data,
  output logic               sclk,
  output logic               sdata,
  output logic               le,
  output logic               busy,
  output logic               overrun
);
  logic               seq_busy, start, assembling;
  logic [FRAME_W-1:0] frame;

  sl_chunk_asm #(.FRAME_W(FRAME_W), .CHUNK_W(CHUNK_W)) u_asm (
    .clk(clk), .rst(rst), .abort(abort), .seq_busy(seq_busy),
    .word_valid(word_valid), .word_data(word_data),
    .chunk_valid(chunk_valid), .chunk_data(chunk_data),
    .start(start), .frame(frame), .assembling(assembling), .overrun(overrun)
  );

  sl_shift_seq #(.FRAME_W(FRAME_W), .HALF_DIV(HALF_DIV), .HOLD_CYC(HOLD_CYC)) u_seq (
    .clk(clk), .rst(rst), .start(start), .frame(frame), .mode(mode),
    .sclk(sclk), .sdata(sdata), .le(le), .busy(seq_busy)
  );

  assign busy = assembling | seq_busy;
endmodule

// File: rtl/synth_loader_chk.sv
module synth_loader_chk (
  input logic clk,
  input logic rst,
  input logic mode,
  input logic word_valid,
  input logic sclk,
  input logic sdata,
  input logic le,
  input logic busy,
  input logic overrun
);
  AST_SDATA_STEADY_HIGH: assert property (@(posedge clk) disable iff (rst)
    (sclk && $past(sclk)) |-> $stable(sdata)); // R3
  AST_SCLK_IDLE_LOW: assert property (@(posedge clk) disable iff (rst)
    !busy |-> !sclk); // R4
  AST_LE_LOW_AT_RISE: assert property (@(posedge clk) disable iff (rst)
    $rose(sclk) |-> !le); // R5
  AST_WORD_OVERRUN: assert property (@(posedge clk) disable iff (rst)
    (word_valid && busy) |=> overrun); // R8
  AST_IDLE_LE_FOLLOWS_MODE: assert property (@(posedge clk) disable iff (rst)
    (!busy && $past(!busy)) |-> (le == $past(mode))); // R10
endmodule

bind synth_loader synth_loader_chk u_chk (
  .clk(clk), .rst(rst), .mode(mode), .word_valid(word_valid),
  .sclk(sclk), .sdata(sdata), .le(le), .busy(busy), .overrun(overrun)
);

// File: tb/sim_synth_loader.sv
module sim_synth_loader;
  localparam int FW   = 21;
  localparam int CWD  = 7;
  localparam int HALF = 2;
  localparam int HOLD = 5;

  logic clk = 1'b0;
  logic rst, abort, mode, word_valid, chunk_valid;
  logic [FW-1:0]  word_data;
  logic [CWD-1:0] chunk_data;
  logic sclk, sdata, le, busy, overrun;

  int vectors = 0;
  int errs = 0;

  typedef struct packed { logic [FW-1:0] d; logic m; } exp_t;
  exp_t q[$];

  always #10 clk = ~clk;

  synth_loader #(.FRAME_W(FW), .CHUNK_W(CWD), .HALF_DIV(HALF), .HOLD_CYC(HOLD)) u0 (
    .clk(clk), .rst(rst), .abort(abort), .mode(mode),
    .word_valid(word_valid), .word_data(word_data),
    .chunk_valid(chunk_valid), .chunk_data(chunk_data),
    .sclk(sclk), .sdata(sdata), .le(le), .busy(busy), .overrun(overrun)
  );

  task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    vectors++;
    if (!ok) begin
      errs++;
      $display("FAIL %s actual=%h expected=%h at %0t", req, act, exp, $time);
    end
  endtask

  // monitor: one sample per system cycle, away from the active edge
  logic p_sclk = 1'b0, p_sdata = 1'b0, p_le = 1'b0;
  int bits = 0, since = 0, le_low = 0, lew = 0;
  logic [FW-1:0] word = '0;

  task automatic finish_frame();
    exp_t e;
    e = q.pop_front();
    chk(word == e.d, "R1 R2 frame data", 32'(word), 32'(e.d));
    chk(!busy, "R7 busy at latch end", 32'(busy), 0);
    bits = 0;
  endtask

  always @(negedge clk) begin
    if (!rst) begin
      le_low = le ? 0 : le_low + 1;
      if (sclk && !p_sclk) begin
        if (bits == 0) chk(le_low >= HALF + 1, "R6 le leads first edge", le_low, HALF + 1);
        else chk(since == 2*HALF - 1, "R4 sclk period", since, 2*HALF - 1);
        chk(!le, "R5 le low at rise", 32'(le), 0);
        chk(bits < FW, "R1 bit count", bits, FW - 1);
        word  = {word[FW-2:0], sdata};
        bits++;
        since = 0;
      end else since++;
      if (sclk && p_sclk && sdata != p_sdata)
        chk(0, "R3 data moved while sclk high", 32'(sdata), 32'(p_sdata));
      if (bits == FW) begin
        if (le && !p_le) begin
          if (q.size() == 0) begin
            chk(0, "R8 R9 unexpected frame", 32'(word), 0);
            bits = 0;
          end else if (!q[0].m) begin
            chk(since >= HALF, "R5 pulse delay", since, HALF);
            lew = 1;
          end else begin
            chk(since >= HOLD, "R6 gate hold", since, HOLD);
            finish_frame();
          end
        end else if (le && p_le) lew++;
        else if (!le && p_le && q.size() != 0) begin
          chk(lew == 2*HALF, "R5 pulse width", lew, 2*HALF);
          finish_frame();
        end
      end
      p_sclk = sclk; p_sdata = sdata; p_le = le;
    end
  end

  task automatic wait_idle();
    do @(negedge clk); while (busy);
    repeat (2) @(negedge clk);
  endtask

  task automatic send_word(input logic [FW-1:0] d, input logic m);
    mode = m;
    word_data = d; word_valid = 1'b1;
    q.push_back('{d: d, m: m});
    @(negedge clk);
    word_valid = 1'b0;
    chk(busy, "R7 busy after word", 32'(busy), 1);
  endtask

  task automatic send_chunks(input logic [CWD-1:0] a, input logic [CWD-1:0] b,
                             input logic [CWD-1:0] c, input logic m);
    mode = m;
    q.push_back('{d: {a, b, c}, m: m});
    chunk_data = a; chunk_valid = 1'b1;
    @(negedge clk); chunk_valid = 1'b0;
    chk(busy, "R7 busy after first chunk", 32'(busy), 1);
    repeat (3) @(negedge clk);
    chk(!sclk, "R2 no clock before last chunk", 32'(sclk), 0);
    chunk_data = b; chunk_valid = 1'b1;
    @(negedge clk); chunk_valid = 1'b0;
    repeat (2) @(negedge clk);
    chunk_data = c; chunk_valid = 1'b1;
    @(negedge clk); chunk_valid = 1'b0;
  endtask

  initial begin
    rst = 1'b1; abort = 1'b0; mode = 1'b0; word_valid = 1'b0; chunk_valid = 1'b0;
    word_data = '0; chunk_data = '0;
    repeat (4) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    chk(!sclk, "R4 reset sclk", 32'(sclk), 0);
    chk(!busy, "R7 reset busy", 32'(busy), 0);
    chk(!overrun, "R8 reset overrun", 32'(overrun), 0);
    chk(le == mode, "R10 reset le", 32'(le), 32'(mode));

    send_word(21'h15A5C3, 1'b0); wait_idle();
    send_word(21'h1F0F0E, 1'b1); wait_idle();
    send_chunks(7'h55, 7'h2A, 7'h7F, 1'b0); wait_idle();
    send_chunks(7'h01, 7'h40, 7'h33, 1'b1); wait_idle();
    send_word(21'h1FFFFF, 1'b0); wait_idle();
    send_word(21'h000000, 1'b1); wait_idle();

    // R9 abort of a partial frame
    mode = 1'b0;
    chunk_data = 7'h11; chunk_valid = 1'b1; @(negedge clk); chunk_valid = 1'b0;
    chunk_data = 7'h22; chunk_valid = 1'b1; @(negedge clk); chunk_valid = 1'b0;
    abort = 1'b1; @(negedge clk); abort = 1'b0;
    chk(!busy, "R9 busy cleared by abort", 32'(busy), 0);
    send_chunks(7'h3C, 7'h5A, 7'h66, 1'b0); wait_idle();

    // R8 input during a transfer
    send_word(21'h0ABCDE, 1'b1);
    repeat (10) @(negedge clk);
    chunk_data = 7'h7E; chunk_valid = 1'b1; @(negedge clk); chunk_valid = 1'b0;
    chk(overrun, "R8 chunk overrun", 32'(overrun), 1);
    word_data = 21'h123456; word_valid = 1'b1; @(negedge clk); word_valid = 1'b0;
    chk(overrun, "R8 word overrun", 32'(overrun), 1);
    @(negedge clk);
    chk(!overrun, "R8 overrun one cycle", 32'(overrun), 0);
    wait_idle();

    // R10 mode captured at start
    send_word(21'h0C3A51, 1'b1);
    mode = 1'b0;
    wait_idle();

    // R10 idle le follows mode
    mode = 1'b1; repeat (2) @(negedge clk);
    chk(le, "R10 idle le gate style", 32'(le), 1);
    mode = 1'b0; repeat (2) @(negedge clk);
    chk(!le, "R10 idle le pulse style", 32'(le), 0);

    repeat (20) @(negedge clk);
    chk(q.size() == 0, "R9 all frames sent once", q.size(), 0);
    chk(bits == 0, "R1 no stray bits", bits, 0);
    $display("== %0d vectors applied, %0d miscompares ==", vectors, errs);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    errs++;
    $display("FAIL watchdog expired actual=hung expected=done");
    $display("== %0d vectors applied, %0d miscompares ==", vectors, errs);
    $finish;
  end
endmodule